// File: doc/BRIEF.md
# Power allocation indicator encoder

This block tells the load behind a powered device how much power it was granted during classification. While the device is still unpowered, it counts the classification events that arrive. When classification is marked complete, it combines that count with the requested class and with two identification flags, and it keeps the resulting grant. The granted level therefore follows the number of classification cycles the power source chose to send, so a source that grants less than was requested (a demotion) is reported correctly without any special handling.

Three indicator pins carry the result: a high indicator, a low indicator and a flag for a Type 3/4 mutual-identification source. Each pin has a data bit and an active-high output enable that models a pin left floating. A strap input selects one of two encodings. In parallel mode both indicators carry static levels. In serial mode only the low indicator is used, and it carries a static level or a duty-cycle square wave. The pins stay released until the converter reports that soft-start is done. They float again on a fault or on loss of soft-start, and the stored grant survives until the supply-below-threshold reset.

The controller has four states. CLASSIFY counts events. WAIT_SS holds the grant with the pins released. ACTIVE drives the pins. FLOAT releases the pins after a fault or a soft-start drop. The transitions are:
- CLASSIFY→WAIT_SS on the classification-complete input, where the grant is captured.
- WAIT_SS→ACTIVE when soft-start is done and no fault is present.
- ACTIVE→FLOAT on a fault or on soft-start going low.
- FLOAT→WAIT_SS once soft-start is low and the fault has cleared, so that the pins come back only after a new soft-start completes.

Top module: `pai_encoder`

## Requirements
- R1: While `rst_n` is low, `hi_oe`, `lo_oe` and `bt_oe` are 0. The block leaves reset in CLASSIFY with no events counted.
- R2: Each clock cycle with `cls_evt` high, in CLASSIFY and with `cls_done` low, adds one event. The count saturates at 4, so 9 events act like 4. An event in the same cycle as `cls_done`, or any later event, is not counted.
- R3: With fewer than 2 events and no high-power identification, the grant is the standard level. In parallel mode the outputs are `hi_ind`=1 and `lo_ind`=1.
- R4: With 2 or more events, a class of 4 or above (codes 4 to 7) and no higher grant, the grant is 25.5 W. This includes class 5 or 6 demoted by 2 or 3 events. In parallel mode the outputs are `hi_ind`=1 and `lo_ind`=0.
- R5: With 4 events and class 5 or 6, the grant is the 40/51 W level. In parallel mode the outputs are `hi_ind`=0 and `lo_ind`=1.
- R6: `vhp_id` high with class 5 or 6 at capture gives the vendor high-power grant, whatever the event count. In parallel mode it encodes as `hi_ind`=0 and `lo_ind`=1.
- R7: With `par_sel`=0 (serial), `hi_oe` stays 0. `lo_ind` is constantly 1 for the standard grant and constantly 0 for the 25.5 W grant.
- R8: In serial mode the waveform has a period of 1024 cycles, counted from 0 on the first ACTIVE cycle. The 40/51 W grant drives `lo_ind` low for phases 0 to 255. The vendor high-power grant drives it low for phases 0 to 511. The phase restarts at 0 each time the outputs are enabled.
- R9: When enabled, `bt_ind` equals the value `bt_id` had in the capture cycle.
- R10: The pins become enabled one cycle after `ss_done` is sampled high in WAIT_SS with `fault` low. They are never enabled in the cycle after `ss_done` was sampled low.
- R11: A cycle with `fault` high releases all pins in the next cycle. Re-enabling needs `ss_done` to go low and then high again with no fault. After that the pins show the same grant and flag as before, even if the class inputs changed in between.
- R12: Asserting `rst_n` low clears the held grant. A new classification after reset determines the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Supply-below-threshold reset, active low, asynchronous |
| cls_evt | input | 1 | Classification event strobe, one count per high cycle |
| cls_done | input | 1 | Classification complete; freezes the count and captures the grant |
| req_class | input | 3 | Requested device class, 0 to 7 |
| vhp_id | input | 1 | Vendor high-power source identified |
| bt_id | input | 1 | Type 3/4 mutual-identification source identified |
| par_sel | input | 1 | 1 = parallel encoding, 0 = serial encoding |
| ss_done | input | 1 | Converter soft-start complete |
| fault | input | 1 | Any disable or fault condition |
| hi_ind | output | 1 | High indicator data |
| hi_oe | output | 1 | High indicator output enable |
| lo_ind | output | 1 | Low indicator data |
| lo_oe | output | 1 | Low indicator output enable |
| bt_ind | output | 1 | Type 3/4 flag data |
| bt_oe | output | 1 | Type 3/4 flag output enable |

## Verification
The pins are combinational decodes of registered state. A change in `ss_done`, `fault` or `cls_done` sampled at one rising edge therefore shows on the pins right after that edge. The bench drives inputs on falling edges and reads the pins on the following falling edge. `par_sel` acts on the pins within the same cycle. In serial mode the falling edge k cycles after activation shows phase k, so the duty-cycle checks land exactly on phases 0, 255, 256, 511, 512, 1023 and 1024.

// File: rtl/pai_pkg.sv
package pai_pkg;

    // Granted power level, ordered by increasing allocation
    typedef enum logic [1:0] {
        GR_STD  = 2'd0,   // one classification cycle or fewer
        GR_MID  = 2'd1,   // 25.5 W
        GR_HIGH = 2'd2,   // 40 W / 51 W
        GR_VHP  = 2'd3    // vendor high-power identification
    } grant_e;

    typedef enum logic [1:0] {
        ST_CLASSIFY = 2'd0,
        ST_WAIT_SS  = 2'd1,
        ST_ACTIVE   = 2'd2,
        ST_FLOAT    = 2'd3
    } state_e;

endpackage

// File: rtl/pai_evt_counter.sv
module pai_evt_counter #(
    parameter int MAX_EVT = 4,
    parameter int CW      = $clog2(MAX_EVT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic          evt,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_EVT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (count_en && evt && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pai_grant_decode.sv
module pai_grant_decode
    import pai_pkg::*;
#(
    parameter int CW       = 3,
    parameter int FULL_CYC = 4,
    parameter int MID_CYC  = 2
) (
    input  logic [CW-1:0] cnt,
    input  logic [2:0]    req_class,
    input  logic          vhp_id,
    output grant_e        grant
);
    localparam logic [CW-1:0] FULL_N = CW'(FULL_CYC);
    localparam logic [CW-1:0] MID_N  = CW'(MID_CYC);

    logic wants_top;   // class 5 or 6
    logic wants_mid;   // class 4 and above

    always_comb begin
        wants_top = (req_class == 3'd5) || (req_class == 3'd6);
        wants_mid = (req_class >= 3'd4);
        if (vhp_id && wants_top) begin
            grant = GR_VHP;
        end else if (wants_top && (cnt >= FULL_N)) begin
            grant = GR_HIGH;
        end else if (wants_mid && (cnt >= MID_N)) begin
            grant = GR_MID;
        end else begin
            grant = GR_STD;
        end
    end
endmodule

// File: rtl/pai_duty_gen.sv
module pai_duty_gen
    import pai_pkg::*;
#(
    parameter int PERIOD = 1024,
    parameter int PW     = $clog2(PERIOD)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  grant_e grant,
    output logic   level
);
    localparam logic [PW-1:0] LAST   = PW'(PERIOD - 1);
    localparam logic [PW-1:0] Q_LOW  = PW'(PERIOD / 4);
    localparam logic [PW-1:0] H_LOW  = PW'(PERIOD / 2);

    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        unique case (grant)
            GR_STD:  level = 1'b1;
            GR_MID:  level = 1'b0;
            GR_HIGH: level = (phase >= Q_LOW);
            GR_VHP:  level = (phase >= H_LOW);
            default: level = 1'b1;
        endcase
    end
endmodule

// File: rtl/pai_encoder.sv
module pai_encoder
    import pai_pkg::*;
#(
    parameter int MAX_EVT = 4,
    parameter int PERIOD  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cls_evt,
    input  logic       cls_done,
    input  logic [2:0] req_class,
    input  logic       vhp_id,
    input  logic       bt_id,
    input  logic       par_sel,
    input  logic       ss_done,
    input  logic       fault,
    output logic       hi_ind,
    output logic       hi_oe,
    output logic       lo_ind,
    output logic       lo_oe,
    output logic       bt_ind,
    output logic       bt_oe
);
    localparam int CW = $clog2(MAX_EVT + 1);

    state_e        state_q, state_d;
    grant_e        grant_q, grant_w;
    logic          bt_q;
    logic [CW-1:0] evt_cnt;
    logic          count_en;
    logic          active;
    logic          ser_lvl;

    assign count_en = (state_q == ST_CLASSIFY) && !cls_done;
    assign active   = (state_q == ST_ACTIVE);

    pai_evt_counter #(.MAX_EVT(MAX_EVT), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .evt      (cls_evt),
        .cnt      (evt_cnt)
    );

    pai_grant_decode #(.CW(CW), .FULL_CYC(MAX_EVT), .MID_CYC(2)) u_dec (
        .cnt       (evt_cnt),
        .req_class (req_class),
        .vhp_id    (vhp_id),
        .grant     (grant_w)
    );

    pai_duty_gen #(.PERIOD(PERIOD)) u_duty (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .grant (grant_q),
        .level (ser_lvl)
    );

    // State register and held grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLASSIFY;
            grant_q <= GR_STD;
            bt_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_CLASSIFY) && cls_done) begin
                grant_q <= grant_w;
                bt_q    <= bt_id;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLASSIFY: if (cls_done)              state_d = ST_WAIT_SS;
            ST_WAIT_SS:  if (ss_done && !fault)     state_d = ST_ACTIVE;
            ST_ACTIVE:   if (fault || !ss_done)     state_d = ST_FLOAT;
            ST_FLOAT:    if (!ss_done && !fault)    state_d = ST_WAIT_SS;
            default:                                state_d = ST_CLASSIFY;
        endcase
    end

    // Pin outputs
    always_comb begin
        hi_oe  = active && par_sel;
        lo_oe  = active;
        bt_oe  = active;
        hi_ind = hi_oe && !((grant_q == GR_HIGH) || (grant_q == GR_VHP));
        lo_ind = active && (par_sel ? (grant_q != GR_MID) : ser_lvl);
        bt_ind = active && bt_q;
    end
endmodule

// File: rtl/pai_encoder_chk.sv
module pai_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic par_sel,
    input logic ss_done,
    input logic fault,
    input logic hi_ind,
    input logic hi_oe,
    input logic lo_ind,
    input logic lo_oe,
    input logic bt_ind,
    input logic bt_oe
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!hi_oe && !lo_oe && !bt_oe);
        end
    end

    a_r10_wait_soft_start: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> (!hi_oe && !lo_oe && !bt_oe));

    a_r11_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!hi_oe && !lo_oe && !bt_oe));

    a_r7_serial_no_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !par_sel |-> !hi_oe);

    a_r11_parallel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && $past(par_sel) && lo_oe && $past(lo_oe))
        |-> ($stable(hi_ind) && $stable(lo_ind) && $stable(bt_ind)));
endmodule

bind pai_encoder pai_encoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .par_sel (par_sel),
    .ss_done (ss_done),
    .fault   (fault),
    .hi_ind  (hi_ind),
    .hi_oe   (hi_oe),
    .lo_ind  (lo_ind),
    .lo_oe   (lo_oe),
    .bt_ind  (bt_ind),
    .bt_oe   (bt_oe)
);

// File: tb/sim_pai_encoder.sv
`timescale 1ns/1ps
module sim_pai_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cls_evt = 1'b0, cls_done = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic       vhp_id = 1'b0, bt_id = 1'b0, par_sel = 1'b1;
    logic       ss_done = 1'b0, fault = 1'b0;
    logic       hi_ind, hi_oe, lo_ind, lo_oe, bt_ind, bt_oe;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pai_encoder u0 (.*);

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cls_evt = 0; cls_done = 0; req_class = 0;
        vhp_id = 0; bt_id = 0; ss_done = 0; fault = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reset, n events, capture, soft-start; returns at first active negedge
    task automatic setup(input int n, input logic [2:0] c, input logic v,
                         input logic b, input logic ps);
        do_reset();
        par_sel = ps;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cls_evt = 1'b1;
            @(negedge clk) cls_evt = 1'b0;
        end
        @(negedge clk);
        req_class = c; vhp_id = v; bt_id = b; cls_done = 1'b1;
        @(negedge clk) ss_done = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_par(input string req, input logic h, input logic l, input logic b);
        chk(req, "hi_oe", hi_oe, 1'b1);
        chk(req, "lo_oe", lo_oe, 1'b1);
        chk(req, "bt_oe", bt_oe, 1'b1);
        chk(req, "hi_ind", hi_ind, h);
        chk(req, "lo_ind", lo_ind, l);
        chk(req, "bt_ind", bt_ind, b);
    endtask

    task automatic t_reset_state();   // R1
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "hi_oe", hi_oe, 1'b0);
        chk("R1", "lo_oe", lo_oe, 1'b0);
        chk("R1", "bt_oe", bt_oe, 1'b0);
    endtask

    task automatic t_grants();   // R3 R4 R5 R9
        setup(1, 3'd6, 1'b0, 1'b0, 1'b1); expect_par("R3", 1, 1, 0);
        setup(0, 3'd2, 1'b0, 1'b1, 1'b1); expect_par("R3", 1, 1, 1);
        setup(3, 3'd4, 1'b0, 1'b1, 1'b1); expect_par("R4", 1, 0, 1);
        setup(2, 3'd5, 1'b0, 1'b0, 1'b1); expect_par("R4", 1, 0, 0);
        setup(4, 3'd4, 1'b0, 1'b0, 1'b1); expect_par("R4", 1, 0, 0);
        setup(4, 3'd7, 1'b0, 1'b0, 1'b1); expect_par("R4", 1, 0, 0);
        setup(4, 3'd5, 1'b0, 1'b1, 1'b1); expect_par("R5", 0, 1, 1);
        setup(4, 3'd6, 1'b0, 1'b0, 1'b1); expect_par("R9", 0, 1, 0);
    endtask

    task automatic t_counter();   // R2
        setup(9, 3'd5, 1'b0, 1'b0, 1'b1); expect_par("R2", 0, 1, 0);
        // event together with cls_done and afterwards: not counted
        do_reset();
        par_sel = 1'b1;
        @(negedge clk) cls_evt = 1'b1;
        @(negedge clk) cls_evt = 1'b0;
        @(negedge clk) begin cls_evt = 1'b1; cls_done = 1'b1; req_class = 3'd4; end
        @(negedge clk) cls_evt = 1'b0;
        @(negedge clk) cls_evt = 1'b1;
        @(negedge clk) begin cls_evt = 1'b0; ss_done = 1'b1; end
        @(negedge clk);
        expect_par("R2", 1, 1, 0);
    endtask

    task automatic t_vhp();   // R6
        setup(1, 3'd5, 1'b1, 1'b0, 1'b1); expect_par("R6", 0, 1, 0);
        setup(2, 3'd4, 1'b1, 1'b0, 1'b1); expect_par("R6", 1, 0, 0);
    endtask

    task automatic t_serial_static();   // R7
        setup(1, 3'd0, 1'b0, 1'b0, 1'b0);
        chk("R7", "hi_oe", hi_oe, 1'b0);
        chk("R7", "lo_oe", lo_oe, 1'b1);
        repeat (600) @(negedge clk);
        chk("R7", "std lo_ind", lo_ind, 1'b1);
        setup(3, 3'd4, 1'b0, 1'b0, 1'b0);
        chk("R7", "hi_oe", hi_oe, 1'b0);
        repeat (600) @(negedge clk);
        chk("R7", "mid lo_ind", lo_ind, 1'b0);
        par_sel = 1'b1;
        #1 chk("R7", "strap back hi_oe", hi_oe, 1'b1);
    endtask

    task automatic t_serial_wave(input logic v, input int edge_k);   // R8
        setup(4, 3'd5, v, 1'b0, 1'b0);
        chk("R8", "phase0 low", lo_ind, 1'b0);
        for (int k = 1; k <= 1024; k++) begin
            @(negedge clk);
            if (k == edge_k - 1) chk("R8", "last low phase", lo_ind, 1'b0);
            if (k == edge_k)     chk("R8", "first high phase", lo_ind, 1'b1);
            if (k == 1023)       chk("R8", "phase1023 high", lo_ind, 1'b1);
            if (k == 1024)       chk("R8", "wrap low", lo_ind, 1'b0);
        end
    endtask

    task automatic t_wait_ss();   // R10
        do_reset();
        par_sel = 1'b1;
        @(negedge clk) cls_done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "lo_oe before ss", lo_oe, 1'b0);
        fault = 1'b1; ss_done = 1'b1;
        @(negedge clk);
        chk("R10", "lo_oe under fault", lo_oe, 1'b0);
        fault = 1'b0;
        @(negedge clk);
        chk("R10", "lo_oe after ss", lo_oe, 1'b1);
    endtask

    task automatic t_fault_hold();   // R11
        setup(3, 3'd4, 1'b0, 1'b1, 1'b1);
        expect_par("R11", 1, 0, 1);
        fault = 1'b1; req_class = 3'd0; bt_id = 1'b0;
        @(negedge clk);
        chk("R11", "lo_oe on fault", lo_oe, 1'b0);
        chk("R11", "bt_oe on fault", bt_oe, 1'b0);
        fault = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "stays released", lo_oe, 1'b0);
        ss_done = 1'b0;
        @(negedge clk) ss_done = 1'b1;
        @(negedge clk);
        expect_par("R11", 1, 0, 1);
        // serial phase restarts on re-enable
        setup(4, 3'd6, 1'b0, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        chk("R11", "serial high mid-period", lo_ind, 1'b1);
        ss_done = 1'b0;
        @(negedge clk);
        @(negedge clk) ss_done = 1'b1;
        @(negedge clk);
        chk("R8", "phase restarts low", lo_ind, 1'b0);
    endtask

    task automatic t_reset_clears();   // R12
        setup(3, 3'd4, 1'b0, 1'b1, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R12", "lo_oe in reset", lo_oe, 1'b0);
        rst_n = 1'b1; cls_done = 1'b0; ss_done = 1'b0;
        req_class = 3'd4; bt_id = 1'b0;
        @(negedge clk) cls_done = 1'b1;
        @(negedge clk) ss_done = 1'b1;
        @(negedge clk);
        expect_par("R12", 1, 1, 0);
    endtask

    initial begin
        t_reset_state();
        t_grants();
        t_counter();
        t_vhp();
        t_serial_static();
        t_serial_wave(1'b0, 256);
        t_serial_wave(1'b1, 512);
        t_wait_ss();
        t_fault_hold();
        t_reset_clears();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule